// File: doc/BRIEF.md
# Overcurrent Fault Counter with Hiccup Restart

This block supervises the overcurrent behaviour of a switching regulator channel. A tick arrives once per switching cycle, and on that tick the block samples the overcurrent detect. A run of detections in back-to-back cycles is counted. Any detection raises a condition flag. A long unbroken run puts the channel into fault shutdown. Shutdown lasts for a fixed number of soft-start periods. After that wait the block clears its counter and emits a one-clock pulse that starts a new soft-start.

A second protection path handles reverse current. When a negative overcurrent detect is seen, switching stops: the power stage goes to tri-state and an output pull-down is enabled. This state has priority over the forward-current counting. The block stays there until the output is reported back in regulation. It then restarts with the same soft-start pulse.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After synchronous reset, oc_flag, fault_shdn, sw_tristate, pull_dn_en and ss_restart are all low.
- R2: A clock with cyc_tick=1 and oc_det=1 in run mode sets oc_flag high from the next clock on.
- R3: A clock with cyc_tick=1 and oc_det=0 in run mode clears the consecutive count to zero and drives oc_flag low from the next clock, including after a short run of fewer than 4 detections.
- R4: oc_flag stays high through a run of 4 or more consecutive detections and drops only on the next clean cycle.
- R5: The 17th consecutive detection raises fault_shdn from the next clock. A run of 16 that is broken by a clean cycle does not raise it, and counting starts again from zero.
- R6: While fault_shdn is high, cyc_tick, oc_det and neg_oc_det have no effect: oc_flag stays high, sw_tristate stays low.
- R7: During shutdown, the 8th ss_tick deasserts fault_shdn and asserts ss_restart for exactly one clock in that same clock, with oc_flag low. The first 7 ss_ticks change no output.
- R8: After a hiccup restart, 17 fresh consecutive detections are again needed for shutdown; 16 do not suffice.
- R9: neg_oc_det=1 in run mode raises sw_tristate and pull_dn_en from the next clock and clears oc_flag, even when cyc_tick and oc_det are high in the same clock.
- R10: In the negative state, the block leaves only on a clock with in_reg=1 and neg_oc_det=0. That clock drops sw_tristate and pull_dn_en and pulses ss_restart for one clock. While in_reg=0 the state holds.
- R11: ss_tick outside shutdown has no effect on any output.
- R12: oc_det is ignored on clocks where cyc_tick=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock strobe per switching cycle |
| oc_det | input | 1 | Forward overcurrent detected this cycle |
| neg_oc_det | input | 1 | Negative overcurrent detected |
| ss_tick | input | 1 | One-clock strobe per soft-start period |
| in_reg | input | 1 | Output voltage is within regulation |
| oc_flag | output | 1 | Overcurrent condition flag |
| fault_shdn | output | 1 | Fault shutdown, hiccup wait in progress |
| sw_tristate | output | 1 | Power stage held in tri-state |
| pull_dn_en | output | 1 | Output pull-down enabled |
| ss_restart | output | 1 | One-clock request to begin soft-start |

## Verification
The hardest state to reach is the boundary of the shutdown run. The stimulus must hold 16 consecutive detections without shutdown, break the run with a clean cycle, and then deliver a fresh run of exactly 17. The bench drives these runs with a directed loop of cycle ticks. It then walks the hiccup wait one soft-start tick at a time. It tries forward and negative detections inside the wait, to show they are ignored. It checks that only the 8th tick releases the shutdown. After the restart it repeats the 16/17 boundary to show that the counter was cleared.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_HICCUP = 2'd1,
        MODE_NEG    = 2'd2
    } ocp_mode_e;

    typedef struct packed {
        logic shdn;
        logic tri_en;
        logic restart;
    } ocp_ctrl_t;

    function automatic ocp_ctrl_t ctrl_for(ocp_mode_e nxt, logic restart);
        ocp_ctrl_t c;
        c.shdn    = (nxt == MODE_HICCUP);
        c.tri_en  = (nxt == MODE_NEG);
        c.restart = restart;
        return c;
    endfunction

endpackage

// File: rtl/ocp_run_counter.sv
module ocp_run_counter #(
    parameter int unsigned RUN_LIMIT = 17,
    localparam int unsigned CNT_W = $clog2(RUN_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    input  logic oc_det,
    input  logic clear,
    output logic flag,
    output logic trip
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LIMIT - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(RUN_LIMIT);

    logic [CNT_W-1:0] run_cnt;

    assign trip = count_en && oc_det && (run_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else if (count_en) begin
            if (oc_det) begin
                if (run_cnt != TOP) run_cnt <= run_cnt + 1'b1;
                flag <= 1'b1;
            end else begin
                run_cnt <= '0;
                flag    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
    parameter int unsigned WAIT_PERIODS = 8,
    localparam int unsigned W = $clog2(WAIT_PERIODS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic ss_tick,
    output logic done
);
    localparam logic [W-1:0] LAST = W'(WAIT_PERIODS - 1);

    logic [W-1:0] wait_cnt;

    assign done = active && ss_tick && (wait_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) wait_cnt <= '0;
        else if (ss_tick)   wait_cnt <= wait_cnt + 1'b1;
    end
endmodule

// File: rtl/ocp_mode_fsm.sv
module ocp_mode_fsm
    import ocp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trip,
    input  logic      wait_done,
    input  logic      neg_det,
    input  logic      in_reg,
    output logic      run_mode,
    output logic      hiccup_mode,
    output logic      clr_cnt,
    output ocp_ctrl_t ctrl
);
    ocp_mode_e mode, nxt;
    logic      restart_n;

    always_comb begin
        nxt       = mode;
        restart_n = 1'b0;
        clr_cnt   = 1'b0;
        unique case (mode)
            MODE_RUN: begin
                if (neg_det) begin
                    nxt     = MODE_NEG;
                    clr_cnt = 1'b1;
                end else if (trip) begin
                    nxt = MODE_HICCUP;
                end
            end
            MODE_HICCUP: begin
                if (wait_done) begin
                    nxt       = MODE_RUN;
                    restart_n = 1'b1;
                    clr_cnt   = 1'b1;
                end
            end
            MODE_NEG: begin
                if (in_reg && !neg_det) begin
                    nxt       = MODE_RUN;
                    restart_n = 1'b1;
                end
            end
            default: nxt = MODE_RUN;
        endcase
    end

    assign run_mode    = (mode == MODE_RUN);
    assign hiccup_mode = (mode == MODE_HICCUP);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RUN;
            ctrl <= '0;
        end else begin
            mode <= nxt;
            ctrl <= ctrl_for(nxt, restart_n);
        end
    end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
    import ocp_pkg::*;
#(
    parameter int unsigned RUN_LIMIT    = 17,
    parameter int unsigned WAIT_PERIODS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    input  logic oc_det,
    input  logic neg_oc_det,
    input  logic ss_tick,
    input  logic in_reg,
    output logic oc_flag,
    output logic fault_shdn,
    output logic sw_tristate,
    output logic pull_dn_en,
    output logic ss_restart
);
    logic      run_mode, hiccup_mode, clr_cnt, trip, wait_done, count_en;
    ocp_ctrl_t ctrl;

    assign count_en = cyc_tick && run_mode && !neg_oc_det;

    ocp_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk(clk), .rst(rst), .count_en(count_en), .oc_det(oc_det),
        .clear(clr_cnt), .flag(oc_flag), .trip(trip)
    );

    ocp_hiccup_timer #(.WAIT_PERIODS(WAIT_PERIODS)) u_wait (
        .clk(clk), .rst(rst), .active(hiccup_mode), .ss_tick(ss_tick),
        .done(wait_done)
    );

    ocp_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .trip(trip), .wait_done(wait_done),
        .neg_det(neg_oc_det), .in_reg(in_reg), .run_mode(run_mode),
        .hiccup_mode(hiccup_mode), .clr_cnt(clr_cnt), .ctrl(ctrl)
    );

    assign fault_shdn  = ctrl.shdn;
    assign sw_tristate = ctrl.tri_en;
    assign pull_dn_en  = ctrl.tri_en;
    assign ss_restart  = ctrl.restart;
endmodule

// File: rtl/ocp_hiccup_ctrl_chk.sv
module ocp_hiccup_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cyc_tick,
    input logic oc_det,
    input logic neg_oc_det,
    input logic oc_flag,
    input logic fault_shdn,
    input logic sw_tristate,
    input logic pull_dn_en,
    input logic ss_restart
);
    // R7
    restart_single_chk: assert property (@(posedge clk) disable iff (rst)
        ss_restart |=> !ss_restart);

    // R7
    shdn_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_shdn) |-> ss_restart);

    // R10
    restart_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ss_restart |-> (!fault_shdn && !sw_tristate));

    // R5
    shdn_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_shdn) |-> $past(cyc_tick && oc_det));

    // R6
    shdn_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fault_shdn |-> oc_flag);

    // R9
    tri_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_tristate) |-> $past(neg_oc_det));

    // R9
    tri_excl_chk: assert property (@(posedge clk) disable iff (rst)
        sw_tristate |-> (!oc_flag && !fault_shdn && pull_dn_en));

    // R10
    pulldown_pair_chk: assert property (@(posedge clk) disable iff (rst)
        pull_dn_en |-> sw_tristate);
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_ctrl_chk u_chk (.*);

// File: tb/ocp_hiccup_ctrl_bench.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl_bench;
    logic clk = 1'b0;
    logic rst, cyc_tick, oc_det, neg_oc_det, ss_tick, in_reg;
    logic oc_flag, fault_shdn, sw_tristate, pull_dn_en, ss_restart;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    ocp_hiccup_ctrl u_ocp_hiccup_ctrl (.*);

    // {cyc,oc,neg,ss,inreg, exp flag,shdn,tri,restart}
    localparam int NV = 16;
    localparam logic [8:0] VEC [NV] = '{
        9'b11000_1000, // R2 detection raises flag
        9'b01000_1000, // R12 no tick, no change
        9'b10000_0000, // R3 clean cycle clears
        9'b11000_1000,
        9'b11000_1000,
        9'b10000_0000, // R3 short run clears
        9'b00010_0000, // R11 ss_tick in run mode
        9'b11100_0010, // R9 negative wins
        9'b11100_0010,
        9'b00000_0010, // R10 held while out of regulation
        9'b00001_0001, // R10 exit with restart
        9'b00000_0000,
        9'b11000_1000,
        9'b00100_0010, // R9 flag cleared on entry
        9'b00001_0001, // R10
        9'b00000_0000
    };

    task automatic step(input logic c, o, n, s, r);
        cyc_tick = c; oc_det = o; neg_oc_det = n; ss_tick = s; in_reg = r;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {oc_flag, fault_shdn, sw_tristate, ss_restart};
        n_cmp++;
        if (act !== exp || pull_dn_en !== sw_tristate) begin
            n_bad++;
            $display("FAIL %s: flag/shdn/tri/rst=%b pd=%b expected %b pd=%b",
                     req, act, pull_dn_en, exp, exp[1]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc_tick = 0; oc_det = 0; neg_oc_det = 0; ss_tick = 0; in_reg = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset state", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            chk($sformatf("R2/R3/R9-R12 vector %0d", i), VEC[i][3:0]);
        end

        // R4 flag held through a run past 4
        for (int i = 0; i < 6; i++) begin
            step(1, 1, 0, 0, 0);
            chk("R4 long run flag", 4'b1000);
        end
        step(1, 0, 0, 0, 0);
        chk("R4 clean cycle drops flag", 4'b0000);

        // R5 broken run of 16, then 17
        for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0);
        chk("R5 16 detections no shutdown", 4'b1000);
        step(1, 0, 0, 0, 0);
        chk("R5 run broken", 4'b0000);
        for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0);
        chk("R5 second run of 16", 4'b1000);
        step(1, 1, 0, 0, 0);
        chk("R5 17th detection shuts down", 4'b1100);

        // R6 inputs ignored during shutdown
        step(1, 0, 0, 0, 0);
        chk("R6 clean tick ignored", 4'b1100);
        step(0, 0, 1, 0, 1);
        chk("R6 negative ignored", 4'b1100);
        step(1, 1, 0, 0, 0);
        chk("R6 detection ignored", 4'b1100);

        // R7 hiccup wait
        for (int i = 0; i < 7; i++) begin
            step(0, 0, 0, 1, 0);
            chk("R7 wait tick", 4'b1100);
            step(0, 0, 0, 0, 0);
        end
        step(0, 0, 0, 1, 0);
        chk("R7 eighth tick restarts", 4'b0001);
        step(0, 0, 0, 0, 0);
        chk("R7 restart one clock", 4'b0000);

        // R8 counter cleared by restart
        for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0);
        chk("R8 16 after restart", 4'b1000);
        step(1, 1, 0, 0, 0);
        chk("R8 17 after restart", 4'b1100);

        // R1 reset during shutdown
        do_reset();
        chk("R1 reset from shutdown", 4'b0000);
        step(0, 0, 0, 1, 0);
        chk("R11 ss_tick after reset", 4'b0000);

        finished = 1'b1;
        report();
    end
endmodule